// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between the execute stage of a 32-bit datapath and a word-wide data memory. It steers narrow store data into the memory lanes and pulls narrow load data out of the word the memory returns. It uses big-endian byte numbering: byte offset 0 is the most significant lane of the word.

For a store, the block takes an access size, the low bits of the byte address and the register value. It returns a write word that repeats the source byte or halfword across the word, plus four byte-write enables. For a load, it takes the same size and offset, a signed/unsigned flag and the memory word. It returns a full 32-bit register value, sign-extended or zero-extended as the flag asks.

An access whose address does not suit its size is not rotated or split. The block raises a misalign flag for a trap handler elsewhere to act on. The block is purely combinational.

Top module: `lsu_lane_top`

## Requirements
- R1: `accSize` encodes 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 reserved. `addrLow` is the byte offset inside the word. Offset 0 names bits 31:24, offset 1 bits 23:16, offset 2 bits 15:8 and offset 3 bits 7:0.
- R2: A word access raises `misalign` for every offset except 0.
- R3: A halfword access raises `misalign` exactly when `addrLow[0]` is 1.
- R4: A byte access never raises `misalign`. The reserved size always raises it.
- R5: When aligned, `byteEn` is as follows, where `byteEn[3]` enables bits 31:24:
  - byte: 4'b1000 shifted right by the offset;
  - halfword: 4'b1100 at offset 0 and 4'b0011 at offset 2;
  - word: 4'b1111.
- R6: Whenever `misalign` is high, `byteEn` is 4'b0000.
- R7: `writeData` depends only on the size, whatever the alignment:
  - byte: `storeData[7:0]` repeated four times;
  - halfword: `storeData[15:0]` repeated twice;
  - word or reserved: `storeData` unchanged.
- R8: An aligned byte load with `loadSigned`=1 returns the addressed byte of `readData`, sign-extended to 32 bits.
- R9: An aligned byte or halfword load with `loadSigned`=0 returns the selected data zero-extended to 32 bits.
- R10: An aligned halfword load selects bits 31:16 at offset 0 and bits 15:0 at offset 2, then extends them per R8/R9.
- R11: An aligned word load returns `readData` unchanged for either value of `loadSigned`.
- R12: A misaligned access returns `loadData` of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accSize | input | 2 | Access size code (R1) |
| addrLow | input | 2 | Byte offset of the access inside the word |
| loadSigned | input | 1 | 1 = sign-extend narrow loads, 0 = zero-extend |
| storeData | input | 32 | Register value to be stored |
| readData | input | 32 | Word returned by data memory |
| writeData | output | 32 | Replicated word for the memory write port |
| byteEn | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| loadData | output | 32 | Extended load result for the register file |
| misalign | output | 1 | Access address does not suit its size |

## Verification
The store path (lane replication and enables) and the load path (lane extraction and extension) always evaluate together from the same size and offset. A wrong decode can therefore show up in one path and not the other. The bench drives a distinct store value and a distinct memory word in every vector. It judges `writeData`, `byteEn`, `loadData` and `misalign` together against a separately written model. It sweeps every size, offset and signedness with four data patterns. The patterns place set and clear sign bits in each lane.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int DATA_W    = 32;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int OFF_W     = $clog2(NUM_LANES);
  localparam int HALF_W    = 2 * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Strobes from the decode side to the lane datapath
  typedef struct packed {
    logic                 misalign;
    logic [NUM_LANES-1:0] laneEn;
    logic [OFF_W-1:0]     laneIdx;
    logic                 pickByte;
    logic                 pickHalf;
    logic                 signExt;
  } lane_ctrl_t;
endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
(
  input  acc_size_e        sizeCode,
  input  logic [OFF_W-1:0] offset,
  input  logic             wantSigned,
  output lane_ctrl_t       strobes
);
  localparam logic [NUM_LANES-1:0] ALL_LANES  = '1;
  localparam logic [NUM_LANES-1:0] TOP_LANE   = {1'b1, {(NUM_LANES-1){1'b0}}};
  localparam logic [NUM_LANES-1:0] TOP_PAIR   = {2'b11, {(NUM_LANES-2){1'b0}}};

  logic                 badAddr;
  logic [NUM_LANES-1:0] rawEn;

  always_comb begin
    badAddr = 1'b0;
    rawEn   = '0;
    unique case (sizeCode)
      SZ_BYTE: begin
        badAddr = 1'b0;
        rawEn   = TOP_LANE >> offset;
      end
      SZ_HALF: begin
        badAddr = offset[0];
        rawEn   = TOP_PAIR >> offset;
      end
      SZ_WORD: begin
        badAddr = (offset != '0);
        rawEn   = ALL_LANES;
      end
      default: begin
        badAddr = 1'b1;
        rawEn   = '0;
      end
    endcase
  end

  always_comb begin
    strobes.misalign = badAddr;
    strobes.laneEn   = badAddr ? '0 : rawEn;
    strobes.laneIdx  = offset;
    strobes.pickByte = (sizeCode == SZ_BYTE);
    strobes.pickHalf = (sizeCode == SZ_HALF);
    strobes.signExt  = wantSigned;
  end
endmodule

// File: rtl/lsu_lane_dp.sv
module lsu_lane_dp
  import lsu_lane_pkg::*;
(
  input  lane_ctrl_t        strobes,
  input  logic [DATA_W-1:0] regValue,
  input  logic [DATA_W-1:0] memWord,
  output logic [DATA_W-1:0] memWrite,
  output logic [DATA_W-1:0] regResult
);
  localparam int NUM_HALVES = NUM_LANES / 2;

  // Lanes indexed by big-endian offset: laneByOff[0] is the top lane
  logic [LANE_W-1:0] laneByOff [NUM_LANES];
  logic [HALF_W-1:0] halfByIdx [NUM_HALVES];

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    assign laneByOff[gi] = memWord[(NUM_LANES-1-gi)*LANE_W +: LANE_W];
  end

  for (genvar gh = 0; gh < NUM_HALVES; gh++) begin : g_half
    assign halfByIdx[gh] = memWord[(NUM_HALVES-1-gh)*HALF_W +: HALF_W];
  end

  logic [LANE_W-1:0] selByte;
  logic [HALF_W-1:0] selHalf;
  logic [DATA_W-1:0] extended;

  always_comb begin
    selByte = laneByOff[strobes.laneIdx];
    selHalf = halfByIdx[strobes.laneIdx[OFF_W-1:1]];
  end

  always_comb begin
    if (strobes.pickByte)
      extended = {{(DATA_W-LANE_W){strobes.signExt & selByte[LANE_W-1]}}, selByte};
    else if (strobes.pickHalf)
      extended = {{(DATA_W-HALF_W){strobes.signExt & selHalf[HALF_W-1]}}, selHalf};
    else
      extended = memWord;
    regResult = strobes.misalign ? '0 : extended;
  end

  always_comb begin
    if (strobes.pickByte)
      memWrite = {NUM_LANES{regValue[LANE_W-1:0]}};
    else if (strobes.pickHalf)
      memWrite = {NUM_HALVES{regValue[HALF_W-1:0]}};
    else
      memWrite = regValue;
  end
endmodule

// File: rtl/lsu_lane_top.sv
module lsu_lane_top
  import lsu_lane_pkg::*;
(
  input  logic [1:0]           accSize,
  input  logic [OFF_W-1:0]     addrLow,
  input  logic                 loadSigned,
  input  logic [DATA_W-1:0]    storeData,
  input  logic [DATA_W-1:0]    readData,
  output logic [DATA_W-1:0]    writeData,
  output logic [NUM_LANES-1:0] byteEn,
  output logic [DATA_W-1:0]    loadData,
  output logic                 misalign
);
  lane_ctrl_t ctrlStrobes;

  lsu_lane_ctrl u_ctrl (
    .sizeCode   (acc_size_e'(accSize)),
    .offset     (addrLow),
    .wantSigned (loadSigned),
    .strobes    (ctrlStrobes)
  );

  lsu_lane_dp u_dp (
    .strobes   (ctrlStrobes),
    .regValue  (storeData),
    .memWord   (readData),
    .memWrite  (writeData),
    .regResult (loadData)
  );

  assign byteEn   = ctrlStrobes.laneEn;
  assign misalign = ctrlStrobes.misalign;
endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk
  import lsu_lane_pkg::*;
(
  input logic [1:0]           accSize,
  input logic [OFF_W-1:0]     addrLow,
  input logic [DATA_W-1:0]    readData,
  input logic [NUM_LANES-1:0] byteEn,
  input logic [DATA_W-1:0]    loadData,
  input logic                 misalign
);
  always_comb begin
    if (misalign) begin
      p_no_enable_on_misalign_r6: assert (byteEn == '0)
        else $error("byteEn active on misaligned access");
      p_zero_load_on_misalign_r12: assert (loadData == '0)
        else $error("loadData nonzero on misaligned access");
    end
    if (accSize == 2'b00) begin
      p_byte_always_aligned_r4: assert (!misalign)
        else $error("byte access flagged misaligned");
      p_byte_single_lane_r5: assert ($countones(byteEn) == 1)
        else $error("byte store must enable one lane");
    end
    if (accSize == 2'b11) begin
      p_reserved_misaligned_r4: assert (misalign)
        else $error("reserved size not flagged");
    end
    if (accSize == 2'b10 && !misalign) begin
      p_word_all_lanes_r5: assert (byteEn == '1)
        else $error("word store must enable all lanes");
      p_word_load_passthru_r11: assert (loadData == readData)
        else $error("word load altered data");
    end
    if (accSize == 2'b01 && !misalign) begin
      p_half_two_lanes_r5: assert ($countones(byteEn) == 2)
        else $error("half store must enable two lanes");
      p_half_offset_even_r3: assert (addrLow[0] == 1'b0)
        else $error("odd half offset accepted");
    end
  end
endmodule

bind lsu_lane_top lsu_lane_chk u_chk (
  .accSize  (accSize),
  .addrLow  (addrLow),
  .readData (readData),
  .byteEn   (byteEn),
  .loadData (loadData),
  .misalign (misalign)
);

// File: tb/lsu_lane_top_tb.sv
module lsu_lane_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  accSize = '0;
  logic [1:0]  addrLow = '0;
  logic        loadSigned = 1'b0;
  logic [31:0] storeData = '0;
  logic [31:0] readData = '0;
  logic [31:0] writeData;
  logic [3:0]  byteEn;
  logic [31:0] loadData;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  bit driveDone = 1'b0;

  typedef struct {
    logic [1:0]  sz;
    logic [1:0]  off;
    logic        sgn;
    logic [31:0] wd;
    logic [3:0]  en;
    logic [31:0] ld;
    logic        mis;
  } exp_t;

  exp_t expQ[$];

  lsu_lane_top u_dut (
    .accSize    (accSize),
    .addrLow    (addrLow),
    .loadSigned (loadSigned),
    .storeData  (storeData),
    .readData   (readData),
    .writeData  (writeData),
    .byteEn     (byteEn),
    .loadData   (loadData),
    .misalign   (misalign)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model written from the requirements
  function automatic exp_t model(logic [1:0] sz, logic [1:0] off, logic sgn,
                                 logic [31:0] sd, logic [31:0] rd);
    exp_t e;
    logic [7:0]  b;
    logic [15:0] h;
    e.sz = sz; e.off = off; e.sgn = sgn;
    case (sz)
      2'b00: e.mis = 1'b0;
      2'b01: e.mis = off[0];
      2'b10: e.mis = (off != 2'd0);
      default: e.mis = 1'b1;
    endcase
    case (sz)
      2'b00: e.en = 4'b1000 >> off;
      2'b01: e.en = (off == 2'd0) ? 4'b1100 : 4'b0011;
      2'b10: e.en = 4'b1111;
      default: e.en = 4'b0000;
    endcase
    if (e.mis) e.en = 4'b0000;
    case (sz)
      2'b00: e.wd = {sd[7:0], sd[7:0], sd[7:0], sd[7:0]};
      2'b01: e.wd = {sd[15:0], sd[15:0]};
      default: e.wd = sd;
    endcase
    b = 8'(rd >> (8 * (3 - int'(off))));
    h = (off == 2'd0) ? rd[31:16] : rd[15:0];
    if (e.mis) e.ld = 32'd0;
    else if (sz == 2'b00) e.ld = sgn ? {{24{b[7]}}, b} : {24'd0, b};
    else if (sz == 2'b01) e.ld = sgn ? {{16{h[15]}}, h} : {16'd0, h};
    else e.ld = rd;
    return e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, exp_t e);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s size=%0d off=%0d sgn=%0d actual=%h expected=%h",
               req, e.sz, e.off, e.sgn, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] sz, logic [1:0] off, logic sgn,
                       logic [31:0] sd, logic [31:0] rd);
    @(posedge clk);
    accSize = sz; addrLow = off; loadSigned = sgn;
    storeData = sd; readData = rd;
    expQ.push_back(model(sz, off, sgn, sd, rd));
  endtask

  // Monitor: compares away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        string misReq, enReq, ldReq;
        e = expQ.pop_front();
        misReq = (e.sz == 2'b01) ? "R3" : (e.sz == 2'b10) ? "R2" : "R4";
        enReq  = e.mis ? "R6" : "R5";
        if (e.mis)                 ldReq = "R12";
        else if (e.sz == 2'b10)    ldReq = "R11";
        else if (!e.sgn)           ldReq = "R9";
        else if (e.sz == 2'b00)    ldReq = "R1 R8";
        else                       ldReq = "R10";
        check(misReq, {31'd0, misalign}, {31'd0, e.mis}, e);
        check(enReq, {28'd0, byteEn}, {28'd0, e.en}, e);
        check("R7", writeData, e.wd, e);
        check(ldReq, loadData, e.ld, e);
      end
    end
  end

  logic [31:0] pats [4] = '{32'h80FF7F01, 32'h7E8100FF, 32'h12345678, 32'hF0E1D2C3};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle-input state: byte load/store at offset 0 with zero data
    drive(2'b00, 2'd0, 1'b0, 32'd0, 32'd0);
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
        for (int sg = 0; sg < 2; sg++)
          for (int p = 0; p < 4; p++)
            drive(2'(sz), 2'(off), 1'(sg), pats[(p + 1) % 4], pats[p]);
    repeat (3) @(posedge clk);
    driveDone = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!driveDone && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!driveDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule